// File: doc/BRIEF.md
# Shadowed 24-bit Event Timer Comparator

This unit sits beside a free-running 24-bit event timer and raises an event when the timer reaches an absolute compare time. Software programs the unit through two 16-bit register-write ports. The upper word holds a disable control and compare bits 23..16. The lower word holds compare bits 15..0.

Both words first land in holding registers. The comparator that is actually in use, meaning its 24-bit value and its enable state, changes only when the lower word is written. At that point both are loaded together from the current upper holding register and the incoming lower word. The value and enable state therefore switch as one unit, and the comparator never sees a half-updated time. Software may write the two words back to back or as separate writes. A lone lower-word write reuses whatever the upper holding register contains.

A match between the timer and the active value, while the unit is enabled, sets a sticky status flag. The interrupt output follows the visible status. A dedicated strobe clears the flag. The register-write ports are plain one-cycle strobes with no back-pressure: every write is accepted in the cycle it is presented.

Top module: `evcmp_top`

## Requirements
- R1: After reset, the upper read word is 0x00FF and the lower read word is 0xFFFF. The active compare value is 0xFFFFFF and enabled, and `status_o` and `irq_o` are 0.
- R2: An upper-word write stores bit 15 as the disable control and bits 7..0 as compare bits 23..16. Bits 14..8 of the written data are ignored and always read back as 0.
- R3: An upper-word write without a lower-word write leaves the active compare value and the active enable state unchanged.
- R4: A lower-word write loads the active value as {upper holding bits 7..0, written word} and the active disable from upper holding bit 15, both in the same edge. The new value is in effect from the following cycle. If both words are written in the same cycle, the load uses the upper holding contents from before that write.
- R5: A lower-word write on its own reuses the current upper holding register, however long ago it was written.
- R6: When `timer_i` equals the active value during a cycle and the active state is enabled, the status flag is 1 from the next clock edge. It stays 1 until cleared. It never sets without such a match.
- R7: While the active disable is 1, no match sets the flag, and `status_o` and `irq_o` read 0.
- R8: A one-cycle `clr_i` pulse clears the flag at the next edge. If a match occurs in the same cycle, the set wins.
- R9: If a lower-word load and a match occur in the same cycle, the match is judged against the value and enable state that were active before the load.
- R10: `irq_o` always equals `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_i | input | 24 | Current event timer value |
| wr_hi_i | input | 1 | Write strobe for the upper word |
| wr_lo_i | input | 1 | Write strobe for the lower word (triggers the load) |
| wdata_i | input | 16 | Write data for either word |
| clr_i | input | 1 | Clear strobe for the status flag |
| rd_hi_o | output | 16 | Upper holding register read value |
| rd_lo_o | output | 16 | Lower holding register read value |
| status_o | output | 1 | Match status, gated by the active enable |
| irq_o | output | 1 | Interrupt, level of status |

## Verification
A corrupted holding register shows up on the read words in the cycle after the write. It also shows up on `status_o` one edge after the first probe of the expected compare time following the next lower-word load. An active register that is loaded too early, or from the wrong source, makes a probe of the old or new time report the wrong status on the very next edge after the probe. The bench therefore probes both the old and the new times around every write. A wrong enable state is visible immediately, because the enable gates `status_o` combinationally.

// File: rtl/evcmp_pkg.sv
package evcmp_pkg;
  localparam int DEF_TMR_W = 24;
  localparam int DEF_REG_W = 16;

  function automatic int rsv_width(input int tmr_w, input int reg_w);
    return reg_w - 1 - (tmr_w - reg_w);
  endfunction
endpackage

// File: rtl/evcmp_shadow.sv
module evcmp_shadow
  import evcmp_pkg::*;
#(
  parameter int TMR_W = DEF_TMR_W,
  parameter int REG_W = DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_hi,
  output logic [REG_W-1:0] rd_lo,
  output logic [TMR_W-1:0] act_val,
  output logic             act_dis
);
  localparam int HI_W  = TMR_W - REG_W;
  localparam int RSV_W = rsv_width(TMR_W, REG_W);

  logic            hold_dis;
  logic [HI_W-1:0] hold_cmp;
  logic [REG_W-1:0] hold_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_dis <= 1'b0;
      hold_cmp <= '1;
      hold_lo  <= '1;
      act_val  <= '1;
      act_dis  <= 1'b0;
    end else begin
      if (wr_hi) begin
        hold_dis <= wdata[REG_W-1];
        hold_cmp <= wdata[HI_W-1:0];
      end
      if (wr_lo) begin
        hold_lo <= wdata;
        act_val <= {hold_cmp, wdata};
        act_dis <= hold_dis;
      end
    end
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign rd_hi = {hold_dis, {RSV_W{1'b0}}, hold_cmp};
    end else begin : g_norsv
      assign rd_hi = {hold_dis, hold_cmp};
    end
  endgenerate
  assign rd_lo = hold_lo;

  AST_HI_ONLY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> ($stable(act_val) && $stable(act_dis))); // R3

  AST_LO_LOADS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (act_val == {$past(hold_cmp), $past(wdata)} && act_dis == $past(hold_dis))); // R4

  AST_NO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> ($stable(act_val) && $stable(act_dis))); // R5
endmodule

// File: rtl/evcmp_match.sv
module evcmp_match
  import evcmp_pkg::*;
#(
  parameter int TMR_W = DEF_TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] timer,
  input  logic [TMR_W-1:0] act_val,
  input  logic             act_dis,
  input  logic             clr,
  output logic             flag_o
);
  logic hit;

  assign hit = !act_dis && (timer == act_val);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (hit)    flag_o <= 1'b1;
    else if (clr)    flag_o <= 1'b0;
  end

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_o); // R6

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !hit) |=> !flag_o); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_o); // R8

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (act_dis && !flag_o) |=> !flag_o); // R7
endmodule

// File: rtl/evcmp_top.sv
module evcmp_top
  import evcmp_pkg::*;
#(
  parameter int TMR_W = DEF_TMR_W,
  parameter int REG_W = DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] timer_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] rd_hi_o,
  output logic [REG_W-1:0] rd_lo_o,
  output logic             status_o,
  output logic             irq_o
);
  logic [TMR_W-1:0] act_val;
  logic             act_dis;
  logic             flag;

  evcmp_shadow #(.TMR_W(TMR_W), .REG_W(REG_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_hi_i),
    .wr_lo   (wr_lo_i),
    .wdata   (wdata_i),
    .rd_hi   (rd_hi_o),
    .rd_lo   (rd_lo_o),
    .act_val (act_val),
    .act_dis (act_dis)
  );

  evcmp_match #(.TMR_W(TMR_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .timer   (timer_i),
    .act_val (act_val),
    .act_dis (act_dis),
    .clr     (clr_i),
    .flag_o  (flag)
  );

  assign status_o = flag & ~act_dis;
  assign irq_o    = status_o;

  AST_DIS_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    act_dis |-> (!status_o && !irq_o)); // R7

  AST_IRQ_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == status_o); // R10
endmodule

// File: tb/evcmp_top_tb.sv
`timescale 1ns/1ps
module evcmp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] timer = 24'h0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0, clr = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rd_hi, rd_lo;
  logic        status, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] cur_val = 24'hFFFFFF;

  always #2.5 clk = ~clk;

  evcmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .timer_i(timer), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
    .wdata_i(wdata), .clr_i(clr), .rd_hi_o(rd_hi), .rd_lo_o(rd_lo),
    .status_o(status), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [15:0] d);
    wr_hi = hi; wr_lo = !hi; wdata = d;
    tick();
    wr_hi = 0; wr_lo = 0;
  endtask

  task automatic load(input bit dis, input logic [23:0] v);
    wr(1, {dis, 7'h0, v[23:16]});
    wr(0, v[15:0]);
    cur_val = v;
  endtask

  task automatic probe(input logic [23:0] t);
    timer = t;
    tick();
    timer = cur_val ^ 24'h1;
  endtask

  task automatic clear();
    clr = 1; tick(); clr = 0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 rd_hi", rd_hi, 32'h00FF);
    check("R1 rd_lo", rd_lo, 32'hFFFF);
    check("R1 status", status, 0);
    probe(24'hFFFFFF);
    check("R1 default match", status, 1);
    check("R10 irq", irq, 1);
    clear();
    check("R8 clear", status, 0);

    // sweep of compare values: R2 R3 R4 R6
    for (int i = 0; i < 32; i++) begin
      logic [23:0] v;
      v = 24'(i * 32'h05A3C7 + 32'h123);
      wr(1, {1'b0, 7'(i * 5), v[23:16]});
      check("R2 rd_hi", rd_hi, {16'h0, 8'h00, v[23:16]});
      probe(cur_val);
      check("R3 old value active", status, 1);
      clear();
      wr(0, v[15:0]);
      check("R4 rd_lo", rd_lo, {16'h0, v[15:0]});
      probe(cur_val);
      check("R4 old value gone", status, (cur_val == v) ? 1 : 0);
      clear();
      cur_val = v;
      probe(v - 24'h1);
      check("R6 near miss", status, 0);
      probe(v);
      check("R4 new value match", status, 1);
      check("R10 irq", irq, 1);
      tick();
      check("R6 sticky", status, 1);
      clear();
      check("R8 clear", status, 0);
    end

    // R5 lone low write reuses high holding
    load(0, 24'hABCDEF);
    wr(0, 16'h0001);
    cur_val = 24'hAB0001;
    probe(24'hAB0001);
    check("R5 reuse high", status, 1);
    clear();

    // R7 disabled
    load(1, 24'h3C3C3C);
    probe(24'h3C3C3C);
    check("R7 status off", status, 0);
    check("R7 irq off", irq, 0);
    load(0, 24'h3C3C3C);
    check("R7 no flag while disabled", status, 0);
    probe(24'h3C3C3C);
    check("R6 match", status, 1);
    load(1, 24'h3C3C3C);
    check("R7 gated", status, 0);
    load(0, 24'h3C3C3C);
    check("R7 sticky returns", status, 1);
    clear();

    // R8 set beats clear
    timer = cur_val; clr = 1;
    tick();
    clr = 0; timer = cur_val ^ 24'h1;
    check("R8 set wins", status, 1);
    clear();
    check("R8 cleared", status, 0);

    // R9 load and match in same cycle
    load(0, 24'h111111);
    wr(1, 16'h0022);
    wr_lo = 1; wdata = 16'h2222; timer = 24'h111111;
    tick();
    wr_lo = 0; cur_val = 24'h222222; timer = 24'h0;
    check("R9 pre-load match", status, 1);
    clear();
    probe(24'h111111);
    check("R9 old value gone", status, 0);
    probe(24'h222222);
    check("R9 new value", status, 1);
    clear();

    // R4 simultaneous high and low write uses prior high content
    wr_hi = 1; wr_lo = 1; wdata = 16'h8044;
    tick();
    wr_hi = 0; wr_lo = 0; cur_val = 24'h228044;
    check("R2 rd_hi dis", rd_hi, 32'h8044);
    probe(24'h228044);
    check("R4 simultaneous uses old high", status, 1);
    clear();
    wr(0, 16'h8044);
    cur_val = 24'h448044;
    probe(24'h448044);
    check("R7 now disabled", status, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule